// File: doc/BRIEF.md
# Branch Condition Evaluation Unit

This unit decides whether a conditional branch of a 32-bit integer core is taken. It takes two register operands and a 3-bit condition code, and it runs exactly one subtraction of the second operand from the first. From that one subtractor it derives four flags: zero, borrow, signed overflow and an overflow-corrected signed-less-than. All six branch conditions are picked from these flags, so the unit has no magnitude comparators of its own.

The result is a taken flag, an illegal-code flag and the four raw flags, which are brought out for debug. A parameter places a register stage after the condition logic. The register loads when the input strobe is high and clears on synchronous reset. Computing the branch target, fetching instructions and flushing the pipeline are left to the surrounding core.

Top module: `brc_branch_unit`

## Requirements
- R1: Code 3'b000 (equal) reports taken exactly when the subtraction result is all zeros, and code 3'b001 (not equal) reports taken exactly when it is not. flag_zero shows that zero test.
- R2: flag_borrow is 1 exactly when op_a < op_b as unsigned numbers (for example, 1 minus 2 gives borrow 1). Code 3'b110 reports taken when borrow is 1 and code 3'b111 reports taken when borrow is 0.
- R3: flag_slt is the result sign bit XOR the overflow flag, so that a negative first operand paired with a positive second one still reports less-than. Code 3'b100 reports taken when flag_slt is 1 and code 3'b101 reports taken when it is 0.
- R4: flag_ovf is the carry into the most significant bit XOR the carry out of it. It is 1 exactly when operands of opposite sign give a result whose sign differs from op_a.
- R5: flag_slt equals bit 32 of the 33-bit difference of the sign-extended operands, for every operand pair.
- R6: Codes 3'b010 and 3'b011 set illegal to 1 and taken to 0. The six legal codes set illegal to 0.
- R7: With the output register on (the default), all outputs load on the rising clock edge when in_valid is 1, and they hold their values while in_valid is 0.
- R8: A synchronous reset clears taken, illegal and all four flags to 0. Reset takes priority over in_valid in the same cycle.
- R9: The four raw flags are driven for every condition code, including the illegal codes, and depend only on the operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Load strobe for the output register |
| op_a | input | 32 | First operand (minuend) |
| op_b | input | 32 | Second operand (subtrahend) |
| cond | input | 3 | Condition code |
| taken | output | 1 | Branch taken |
| illegal | output | 1 | Condition code is not one of the six legal codes |
| flag_zero | output | 1 | Difference is all zeros |
| flag_borrow | output | 1 | Unsigned borrow out of the subtraction |
| flag_ovf | output | 1 | Signed overflow of the subtraction |
| flag_slt | output | 1 | Signed less-than, corrected for overflow |

## Verification
Two events can fall in the same clock edge: a synchronous reset and a load strobe that carries a pair which would be taken. The bench raises rst and in_valid together with equal operands and the equal code, and it expects every output to read 0 after that edge. A second case is the overflow correction and the unsigned borrow landing in the same subtraction. Pairs such as 0x7FFFFFFF against 0x80000000 make the sign bit alone give the wrong answer while the borrow disagrees with the signed result. The bench judges each flag separately against its own reference model and against the widened-subtraction method.

// File: rtl/brc_pkg.sv
package brc_pkg;

  typedef enum logic [2:0] {
    COND_EQ  = 3'b000,
    COND_NE  = 3'b001,
    COND_LT  = 3'b100,
    COND_GE  = 3'b101,
    COND_LTU = 3'b110,
    COND_GEU = 3'b111
  } cond_e;

  typedef struct packed {
    logic zero;
    logic borrow;
    logic ovf;
    logic slt;
  } brc_flags_t;

  typedef struct packed {
    logic       taken;
    logic       illegal;
    brc_flags_t flags;
  } brc_result_t;

  localparam int unsigned RESULT_W = $bits(brc_result_t);

endpackage

// File: rtl/brc_subtractor.sv
module brc_subtractor #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  output brc_pkg::brc_flags_t flags,
  output logic              msb_carry_in,
  output logic              msb_carry_out
);
  localparam int unsigned TOP = DATA_W - 1;

  // Lower bits of a + ~b + 1; the extra bit is the carry into the MSB.
  function automatic logic [TOP:0] low_add(input logic [DATA_W-1:0] a,
                                          input logic [DATA_W-1:0] b);
    logic [TOP:0] ea, eb, one;
    ea  = {1'b0, a[TOP-1:0]};
    eb  = {1'b0, ~b[TOP-1:0]};
    one = {{TOP{1'b0}}, 1'b1};
    return ea + eb + one;
  endfunction

  // Second method: MSB of a widened difference of sign-extended operands.
  function automatic logic wide_slt(input logic [DATA_W-1:0] a,
                                    input logic [DATA_W-1:0] b);
    logic [DATA_W:0] d;
    d = {a[TOP], a} - {b[TOP], b};
    return d[DATA_W];
  endfunction

  logic [TOP:0]    low_sum;
  logic            inv_b_msb;
  logic            sum_msb;
  logic [TOP:0]    diff;
  logic            slt_wide;

  always_comb begin
    low_sum       = low_add(op_a, op_b);
    msb_carry_in  = low_sum[TOP];
    inv_b_msb     = ~op_b[TOP];
    sum_msb       = op_a[TOP] ^ inv_b_msb ^ msb_carry_in;
    msb_carry_out = (op_a[TOP] & inv_b_msb) | (op_a[TOP] & msb_carry_in)
                  | (inv_b_msb & msb_carry_in);
    diff          = {sum_msb, low_sum[TOP-1:0]};
    flags.zero    = (diff == '0);
    flags.borrow  = ~msb_carry_out;
    flags.ovf     = msb_carry_in ^ msb_carry_out;
    flags.slt     = sum_msb ^ flags.ovf;
    slt_wide      = wide_slt(op_a, op_b);
  end

  always_comb begin
    AST_ZERO_MATCH: assert (flags.zero == (op_a == op_b))
      else $error("zero flag disagrees with operand equality"); // R1
    AST_BORROW_UNSIGNED: assert (flags.borrow == (op_a < op_b))
      else $error("borrow disagrees with unsigned compare"); // R2
    AST_SLT_SIGNED: assert (flags.slt == ($signed(op_a) < $signed(op_b)))
      else $error("slt disagrees with signed compare"); // R3
    AST_OVF_SIGNS: assert (flags.ovf == ((op_a[TOP] != op_b[TOP]) && (diff[TOP] != op_a[TOP])))
      else $error("overflow flag disagrees with sign rule"); // R4
    AST_SLT_WIDE: assert (flags.slt == slt_wide)
      else $error("slt disagrees with widened subtraction"); // R5
  end

endmodule

// File: rtl/brc_cond_select.sv
module brc_cond_select (
  input  logic [2:0]          cond,
  input  brc_pkg::brc_flags_t flags,
  output brc_pkg::brc_result_t result
);
  import brc_pkg::*;

  logic taken_d;
  logic illegal_d;

  always_comb begin
    taken_d   = 1'b0;
    illegal_d = 1'b0;
    case (cond)
      COND_EQ:  taken_d = flags.zero;
      COND_NE:  taken_d = ~flags.zero;
      COND_LT:  taken_d = flags.slt;
      COND_GE:  taken_d = ~flags.slt;
      COND_LTU: taken_d = flags.borrow;
      COND_GEU: taken_d = ~flags.borrow;
      default:  illegal_d = 1'b1;
    endcase
    result.taken   = taken_d;
    result.illegal = illegal_d;
    result.flags   = flags;
  end

  always_comb begin
    AST_ILLEGAL_NOT_TAKEN: assert (!(illegal_d && taken_d))
      else $error("illegal code reported taken"); // R6
    AST_ILLEGAL_CODES: assert (illegal_d == (cond[2:1] == 2'b01))
      else $error("illegal flag wrong for code"); // R6
  end

endmodule

// File: rtl/brc_out_stage.sv
module brc_out_stage #(
  parameter bit REGISTER_OUT = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  brc_pkg::brc_result_t res_d,
  output brc_pkg::brc_result_t res_q
);
  generate
    if (REGISTER_OUT) begin : g_reg
      brc_pkg::brc_result_t held;

      always_ff @(posedge clk) begin
        if (rst)           held <= '0;
        else if (in_valid) held <= res_d;
      end

      assign res_q = held;

      AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (held == '0)); // R8
      AST_LOAD_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (held == $past(res_d))); // R7
      AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(held)); // R7
    end else begin : g_comb
      assign res_q = res_d;
    end
  endgenerate

endmodule

// File: rtl/brc_branch_unit.sv
module brc_branch_unit #(
  parameter int unsigned DATA_W       = 32,
  parameter bit          REGISTER_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [2:0]        cond,
  output logic              taken,
  output logic              illegal,
  output logic              flag_zero,
  output logic              flag_borrow,
  output logic              flag_ovf,
  output logic              flag_slt
);
  import brc_pkg::*;

  brc_flags_t  sub_flags;
  logic        carry_into_msb;
  logic        carry_out_msb;
  brc_result_t res_comb;
  brc_result_t res_out;

  brc_subtractor #(.DATA_W(DATA_W)) u_sub (
    .op_a          (op_a),
    .op_b          (op_b),
    .flags         (sub_flags),
    .msb_carry_in  (carry_into_msb),
    .msb_carry_out (carry_out_msb)
  );

  brc_cond_select u_sel (
    .cond   (cond),
    .flags  (sub_flags),
    .result (res_comb)
  );

  brc_out_stage #(.REGISTER_OUT(REGISTER_OUT)) u_out (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .res_d    (res_comb),
    .res_q    (res_out)
  );

  assign taken       = res_out.taken;
  assign illegal     = res_out.illegal;
  assign flag_zero   = res_out.flags.zero;
  assign flag_borrow = res_out.flags.borrow;
  assign flag_ovf    = res_out.flags.ovf;
  assign flag_slt    = res_out.flags.slt;

  always_comb begin
    AST_BORROW_IS_NOT_CARRY: assert (sub_flags.borrow != carry_out_msb)
      else $error("borrow is not the inverted carry out"); // R2
    AST_OVF_CARRIES: assert (sub_flags.ovf == (carry_into_msb != carry_out_msb))
      else $error("overflow not derived from MSB carries"); // R4
  end

endmodule

// File: tb/tb_brc_branch_unit.sv
module tb_brc_branch_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic [2:0]  cond = 3'b000;
  logic taken, illegal, flag_zero, flag_borrow, flag_ovf, flag_slt;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  brc_branch_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .cond(cond), .taken(taken), .illegal(illegal), .flag_zero(flag_zero),
    .flag_borrow(flag_borrow), .flag_ovf(flag_ovf), .flag_slt(flag_slt)
  );

  task automatic check(input string req, input string what,
                       input logic actual, input logic expected);
    checks++;
    if (actual !== expected) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, actual, expected);
    end
  endtask

  // Reference model stated from the requirements.
  function automatic logic ref_ovf(input logic [31:0] a, input logic [31:0] b);
    logic [31:0] d;
    d = a - b;
    return (a[31] != b[31]) && (d[31] != a[31]);
  endfunction

  function automatic logic ref_slt_wide(input logic [31:0] a, input logic [31:0] b);
    logic [32:0] w;
    w = {a[31], a} - {b[31], b};
    return w[32];
  endfunction

  function automatic logic ref_taken(input logic [31:0] a, input logic [31:0] b,
                                     input logic [2:0] c);
    case (c)
      3'b000:  return a == b;
      3'b001:  return a != b;
      3'b100:  return $signed(a) < $signed(b);
      3'b101:  return $signed(a) >= $signed(b);
      3'b110:  return a < b;
      3'b111:  return a >= b;
      default: return 1'b0;
    endcase
  endfunction

  task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic [2:0] c);
    @(negedge clk);
    op_a = a; op_b = b; cond = c; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic full_check(input string req, input logic [31:0] a,
                            input logic [31:0] b, input logic [2:0] c);
    apply(a, b, c);
    check(req, "taken", taken, ref_taken(a, b, c));
    check(req, "illegal", illegal, c[2:1] == 2'b01);
    check(req, "zero", flag_zero, a == b);
    check(req, "borrow", flag_borrow, a < b);
    check(req, "ovf", flag_ovf, ref_ovf(a, b));
    check(req, "slt", flag_slt, $signed(a) < $signed(b));
  endtask

  task automatic t_reset;
    check("R8", "reset taken", taken, 1'b0);
    check("R8", "reset illegal", illegal, 1'b0);
    check("R8", "reset flags", flag_zero | flag_borrow | flag_ovf | flag_slt, 1'b0);
  endtask

  task automatic t_equality; // R1
    full_check("R1", 32'h1234_5678, 32'h1234_5678, 3'b000);
    full_check("R1", 32'h1234_5678, 32'h1234_5679, 3'b000);
    full_check("R1", 32'h0, 32'h0, 3'b001);
    full_check("R1", 32'h0, 32'hFFFF_FFFF, 3'b001);
  endtask

  task automatic t_unsigned; // R2
    full_check("R2", 32'd1, 32'd2, 3'b110);
    check("R2", "1-2 borrow", flag_borrow, 1'b1);
    full_check("R2", 32'd2, 32'd1, 3'b110);
    full_check("R2", 32'h0, 32'hFFFF_FFFF, 3'b111);
    full_check("R2", 32'hFFFF_FFFF, 32'h0, 3'b111);
    full_check("R2", 32'h8000_0000, 32'h8000_0000, 3'b111);
  endtask

  task automatic t_signed; // R3
    full_check("R3", 32'h8000_0000, 32'h7FFF_FFFF, 3'b100);
    check("R3", "INT_MIN<INT_MAX", taken, 1'b1);
    full_check("R3", 32'h7FFF_FFFF, 32'h8000_0000, 3'b100);
    check("R3", "INT_MAX<INT_MIN", taken, 1'b0);
    full_check("R3", 32'hFFFF_FFFF, 32'hFFFF_FFFE, 3'b101);
    full_check("R3", 32'h0, 32'hFFFF_FFFF, 3'b101);
  endtask

  task automatic t_overflow; // R4
    apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b100);
    check("R4", "MAX-(-1) ovf", flag_ovf, 1'b1);
    apply(32'h8000_0000, 32'h0000_0001, 3'b100);
    check("R4", "MIN-1 ovf", flag_ovf, 1'b1);
    apply(32'h0000_0005, 32'h0000_0003, 3'b100);
    check("R4", "5-3 no ovf", flag_ovf, 1'b0);
  endtask

  task automatic t_wide; // R5
    logic [31:0] x;
    x = 32'h1357_9BDF;
    for (int i = 0; i < 24; i++) begin
      logic [31:0] y;
      y = {x[15:0], x[31:16]} ^ 32'h8000_0001 ^ (i << 27);
      apply(x, y, 3'b100);
      check("R5", "slt vs wide", flag_slt, ref_slt_wide(x, y));
      check("R5", "wide vs signed", ref_slt_wide(x, y), $signed(x) < $signed(y));
      x = {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
    end
  endtask

  task automatic t_illegal; // R6
    full_check("R6", 32'h5, 32'h5, 3'b010);
    full_check("R6", 32'h1, 32'h9, 3'b011);
    check("R6", "code 011 not taken", taken, 1'b0);
  endtask

  task automatic t_hold; // R7
    apply(32'hABCD, 32'hABCD, 3'b000);
    check("R7", "loaded taken", taken, 1'b1);
    @(negedge clk);
    op_b = 32'h1; cond = 3'b110; in_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R7", "hold taken", taken, 1'b1);
    check("R7", "hold zero", flag_zero, 1'b1);
    check("R7", "hold borrow", flag_borrow, 1'b0);
  endtask

  task automatic t_reset_wins; // R8
    @(negedge clk);
    op_a = 32'h42; op_b = 32'h42; cond = 3'b000; in_valid = 1'b1; rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0; in_valid = 1'b0;
    check("R8", "reset over strobe taken", taken, 1'b0);
    check("R8", "reset over strobe zero", flag_zero, 1'b0);
  endtask

  task automatic t_flags_all_codes; // R9
    for (int c = 0; c < 8; c++) begin
      full_check("R9", 32'hFFFF_FFF0, 32'h0000_0010, 3'(c));
    end
  endtask

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_equality();
    t_unsigned();
    t_signed();
    t_overflow();
    t_wide();
    t_illegal();
    t_hold();
    t_reset_wins();
    t_flags_all_codes();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule